// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

The block is a non-blocking time-slot interchange for serial time-division streams. Eight serial inputs, each carrying 32 byte-wide channels per frame, are turned into parallel bytes. Every byte is stored in a two-bank data memory, one bank for each frame parity. Eight serial outputs are then rebuilt slot by slot. For each output slot, a per-slot connect memory entry names the source stream and channel, or it supplies a message byte that replaces switched data. A separate control line carries one bit for each output slot. Each output has its own drive-enable line, which combines a global drive enable with a per-slot enable flag.

All logic runs on one clock, with two clocks per serial bit. A frame pulse restarts the frame timing. Each slot can choose minimum delay, where it sends the freshest stored byte, or constant delay, where it always sends the byte from the previous frame so that multi-channel data keeps its frame alignment. A small synchronous processor port selects a memory through a control register. It writes both halves of the connect memory and reads the connect and data memories.

Top module: `tsi_switch`

## Requirements
- R1: Frame timing. After a cycle in which `fp_i` is high, the next cycle is cycle 0 of a frame, even in the middle of a frame. Without a pulse, the frame wraps every 512 cycles. Channel c occupies cycles 16c to 16c+15. Bit k of a channel (k=0 is the MSB) occupies two cycles, and each input is sampled in the second of them.
- R2: A minimum-delay output slot (stream s, channel c) takes its source from connect-low, which holds {stream[7:5], channel[4:0]}. For c>0 and a source channel below c, the slot sends the byte received in the same frame. Otherwise it sends the byte received in the previous frame. The source channel being received in the slot just before c counts as received (forwarded).
- R3: A constant-delay slot always sends the source byte of the previous frame. This includes channel 0 and source channel 31.
- R4: In message mode, the slot sends its connect-low byte in place of switched data.
- R5: `st_en_o[s]` is high only when `ode_i` is high and the slot's enable flag is set. With `ode_i` low, every output enable is low.
- R6: During channel c, `ctl_o` sends the control flags of output streams 0..7 for channel c, one per bit period, stream 0 first.
- R7: Processor port. With `addr_i[8]`=0 the access targets the control register, whose bits [1:0] select the memory: 0 connect-low, 1 connect-high, 2 data memory (read only). With `addr_i[8]`=1, bits [7:0] are the index {stream, channel}. Connect-high bits are: bit0 message, bit1 enable, bit2 control, bit3 constant delay. Read data appears on `rdata_o` one cycle after the read and is held until the next read.
- R8: A data-memory read returns the byte received on that stream and channel in the previous frame.
- R9: After reset, `rdata_o` is 0, the control register is 0, all output enables are low and `ctl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, two cycles per serial bit |
| rst_ni | input | 1 | Active-low synchronous reset |
| fp_i | input | 1 | Frame pulse, restarts frame timing |
| st_i | input | 8 | Serial input streams |
| ode_i | input | 1 | Global output drive enable |
| cs_i | input | 1 | Processor access strobe |
| we_i | input | 1 | Processor write (1) or read (0) |
| addr_i | input | 9 | Register/memory address |
| wdata_i | input | 8 | Processor write data |
| rdata_o | output | 8 | Processor read data |
| st_o | output | 8 | Serial output streams |
| st_en_o | output | 8 | Per-stream drive enable (low means high impedance) |
| ctl_o | output | 1 | Control bit stream |

## Verification
An output byte for slot c is fetched in the last cycle of slot c-1 and appears in cycles 16c..16c+15. Each bit is held for two cycles, and the bench samples the second one at the falling edge, using its own frame counter driven by the same pulse rule. A constant-delay slot reflects input from exactly one frame earlier. A minimum-delay slot reflects input from the same frame only when its source channel finished before the fetch, so the bench computes the expected frame index for each slot. Processor read data is sampled in the cycle after the access, and enable changes are expected only at slot boundaries, except for the immediate effect of `ode_i`.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [1:0] {
        SEL_CM_LO = 2'd0,
        SEL_CM_HI = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_NONE  = 2'd3
    } memsel_e;

    // per-slot flag word held in connect-high
    typedef struct packed {
        logic cdelay;
        logic ctl;
        logic oe;
        logic msg;
    } slot_flags_t;

    localparam int FLAG_W = $bits(slot_flags_t);

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
    parameter int CHANS = 32,
    parameter int BITS  = 8,
    parameter int CPB   = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     fp_i,
    output logic [$clog2(CHANS)-1:0] chan_o,
    output logic [$clog2(CHANS)-1:0] next_chan_o,
    output logic                     sample_o,
    output logic                     bit_end_o,
    output logic                     slot_end_o,
    output logic                     par_o
);
    localparam int CW = $clog2(CHANS);
    localparam int BW = $clog2(BITS);
    localparam int PW = $clog2(CPB);
    localparam int TW = CW + BW + PW;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          par;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = fp_i ? '0 : s_q.cnt + 1'b1;
        if (s_d.cnt == '0) begin
            s_d.par = ~s_q.par;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic [PW-1:0] phase;
    logic [BW-1:0] bitn;

    assign phase       = s_q.cnt[PW-1:0];
    assign bitn        = s_q.cnt[PW +: BW];
    assign chan_o      = s_q.cnt[PW+BW +: CW];
    assign next_chan_o = chan_o + 1'b1;
    assign sample_o    = (phase == PW'(CPB/2));
    assign bit_end_o   = (phase == PW'(CPB-1));
    assign slot_end_o  = bit_end_o && (bitn == BW'(BITS-1));
    assign par_o       = s_q.par;

endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
    parameter int STREAMS = 8,
    parameter int CHANS   = 32,
    parameter int BITS    = 8
) (
    input  logic                                                 clk_i,
    input  logic                                                 rst_ni,
    input  logic [STREAMS-1:0]                                   st_i,
    input  logic                                                 sample_i,
    input  logic                                                 slot_end_i,
    input  logic [$clog2(CHANS)-1:0]                             chan_i,
    input  logic                                                 par_i,
    input  logic [STREAMS-1:0][$clog2(STREAMS)+$clog2(CHANS)-1:0] rd_addr_i,
    input  logic [STREAMS-1:0]                                   rd_bank_i,
    input  logic [$clog2(STREAMS)+$clog2(CHANS)-1:0]             cpu_addr_i,
    output logic [STREAMS-1:0][BITS-1:0]                         rd_data_o,
    output logic [BITS-1:0]                                      cpu_data_o
);
    localparam int SW    = $clog2(STREAMS);
    localparam int CW    = $clog2(CHANS);
    localparam int AW    = SW + CW;
    localparam int SLOTS = STREAMS * CHANS;

    typedef struct packed {
        logic [STREAMS-1:0][BITS-1:0]      sh;
        logic [1:0][SLOTS-1:0][BITS-1:0]   mem;
    } state_t;

    state_t s_d, s_q;
    logic [STREAMS-1:0][BITS-1:0] byte_in;

    always_comb begin
        s_d = s_q;
        for (int s = 0; s < STREAMS; s++) begin
            byte_in[s] = sample_i ? {s_q.sh[s][BITS-2:0], st_i[s]} : s_q.sh[s];
            if (sample_i) begin
                s_d.sh[s] = byte_in[s];
            end
            if (slot_end_i) begin
                s_d.mem[par_i][{SW'(s), chan_i}] = byte_in[s];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // fetch ports, with forwarding of the byte completing this cycle
    always_comb begin
        for (int s = 0; s < STREAMS; s++) begin
            if (slot_end_i && (rd_bank_i[s] == par_i) &&
                (rd_addr_i[s][CW-1:0] == chan_i)) begin
                rd_data_o[s] = byte_in[rd_addr_i[s][AW-1:CW]];
            end else begin
                rd_data_o[s] = s_q.mem[rd_bank_i[s]][rd_addr_i[s]];
            end
        end
        cpu_data_o = s_q.mem[~par_i][cpu_addr_i];
    end

endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem
    import tsi_pkg::*;
#(
    parameter int STREAMS = 8,
    parameter int CHANS   = 32,
    parameter int BITS    = 8
) (
    input  logic                                     clk_i,
    input  logic                                     rst_ni,
    input  logic                                     cs_i,
    input  logic                                     we_i,
    input  logic [$clog2(STREAMS)+$clog2(CHANS):0]   addr_i,
    input  logic [BITS-1:0]                          wdata_i,
    input  logic [$clog2(CHANS)-1:0]                 next_chan_i,
    output logic [STREAMS-1:0][BITS-1:0]             lo_o,
    output slot_flags_t [STREAMS-1:0]                flags_o,
    output memsel_e                                  sel_o,
    output logic [BITS-1:0]                          cpu_lo_o,
    output slot_flags_t                              cpu_flags_o
);
    localparam int SW    = $clog2(STREAMS);
    localparam int CW    = $clog2(CHANS);
    localparam int AW    = SW + CW;
    localparam int SLOTS = STREAMS * CHANS;

    typedef struct packed {
        logic [SLOTS-1:0][BITS-1:0] lo;
        slot_flags_t [SLOTS-1:0]    hi;
        memsel_e                    sel;
    } state_t;

    state_t s_d, s_q;
    logic [AW-1:0] idx;

    assign idx = addr_i[AW-1:0];

    always_comb begin
        s_d = s_q;
        if (cs_i && we_i) begin
            if (!addr_i[AW]) begin
                s_d.sel = memsel_e'(wdata_i[1:0]);
            end else begin
                case (s_q.sel)
                    SEL_CM_LO: s_d.lo[idx] = wdata_i;
                    SEL_CM_HI: s_d.hi[idx] = slot_flags_t'(wdata_i[FLAG_W-1:0]);
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int s = 0; s < STREAMS; s++) begin
            lo_o[s]    = s_q.lo[{SW'(s), next_chan_i}];
            flags_o[s] = s_q.hi[{SW'(s), next_chan_i}];
        end
    end

    assign sel_o       = s_q.sel;
    assign cpu_lo_o    = s_q.lo[idx];
    assign cpu_flags_o = s_q.hi[idx];

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
    import tsi_pkg::*;
#(
    parameter int STREAMS = 8,
    parameter int CHANS   = 32,
    parameter int BITS    = 8
) (
    input  logic                                                 clk_i,
    input  logic                                                 rst_ni,
    input  logic                                                 bit_end_i,
    input  logic                                                 slot_end_i,
    input  logic [$clog2(CHANS)-1:0]                             chan_i,
    input  logic [$clog2(CHANS)-1:0]                             next_chan_i,
    input  logic                                                 par_i,
    input  logic [STREAMS-1:0][BITS-1:0]                         lo_i,
    input  slot_flags_t [STREAMS-1:0]                            flags_i,
    input  logic [STREAMS-1:0][BITS-1:0]                         dm_i,
    output logic [STREAMS-1:0][$clog2(STREAMS)+$clog2(CHANS)-1:0] src_o,
    output logic [STREAMS-1:0]                                   bank_o,
    output logic [STREAMS-1:0]                                   st_o,
    output logic [STREAMS-1:0]                                   oe_o,
    output logic                                                 ctl_o
);
    localparam int CW = $clog2(CHANS);
    localparam int AW = $clog2(STREAMS) + CW;

    typedef struct packed {
        logic [STREAMS-1:0][BITS-1:0] sh;
        logic [STREAMS-1:0]           oe;
        logic [STREAMS-1:0]           ctl;
    } state_t;

    state_t s_d, s_q;

    // bank choice for the slot being fetched
    always_comb begin
        for (int s = 0; s < STREAMS; s++) begin
            src_o[s] = lo_i[s][AW-1:0];
            if (flags_i[s].cdelay) begin
                bank_o[s] = (next_chan_i == '0) ? par_i : ~par_i;
            end else begin
                bank_o[s] = (lo_i[s][CW-1:0] <= chan_i) ? par_i : ~par_i;
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (slot_end_i) begin
            for (int s = 0; s < STREAMS; s++) begin
                s_d.sh[s]  = flags_i[s].msg ? lo_i[s] : dm_i[s];
                s_d.oe[s]  = flags_i[s].oe;
                s_d.ctl[s] = flags_i[s].ctl;
            end
        end else if (bit_end_i) begin
            for (int s = 0; s < STREAMS; s++) begin
                s_d.sh[s] = {s_q.sh[s][BITS-2:0], 1'b0};
            end
            s_d.ctl = s_q.ctl >> 1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int s = 0; s < STREAMS; s++) begin
            st_o[s] = s_q.sh[s][BITS-1];
        end
    end

    assign oe_o  = s_q.oe;
    assign ctl_o = s_q.ctl[0];

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int STREAMS = 8,
    parameter int CHANS   = 32,
    parameter int BITS    = 8,
    parameter int CPB     = 2
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic                                   fp_i,
    input  logic [STREAMS-1:0]                     st_i,
    input  logic                                   ode_i,
    input  logic                                   cs_i,
    input  logic                                   we_i,
    input  logic [$clog2(STREAMS)+$clog2(CHANS):0] addr_i,
    input  logic [BITS-1:0]                        wdata_i,
    output logic [BITS-1:0]                        rdata_o,
    output logic [STREAMS-1:0]                     st_o,
    output logic [STREAMS-1:0]                     st_en_o,
    output logic                                   ctl_o
);
    localparam int SW = $clog2(STREAMS);
    localparam int CW = $clog2(CHANS);
    localparam int AW = SW + CW;

    logic [CW-1:0]                chan, next_chan;
    logic                         sample, bit_end, slot_end, par;
    logic [STREAMS-1:0][BITS-1:0] cm_lo, dm_data;
    slot_flags_t [STREAMS-1:0]    cm_flags;
    logic [STREAMS-1:0][AW-1:0]   src;
    logic [STREAMS-1:0]           bank, oe;
    memsel_e                      sel;
    logic [BITS-1:0]              cpu_lo, cpu_dm;
    slot_flags_t                  cpu_flags;

    tsi_timing #(.CHANS(CHANS), .BITS(BITS), .CPB(CPB)) u_tim (
        .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i),
        .chan_o(chan), .next_chan_o(next_chan), .sample_o(sample),
        .bit_end_o(bit_end), .slot_end_o(slot_end), .par_o(par)
    );

    tsi_dmem #(.STREAMS(STREAMS), .CHANS(CHANS), .BITS(BITS)) u_dmem (
        .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st_i), .sample_i(sample),
        .slot_end_i(slot_end), .chan_i(chan), .par_i(par),
        .rd_addr_i(src), .rd_bank_i(bank), .cpu_addr_i(addr_i[AW-1:0]),
        .rd_data_o(dm_data), .cpu_data_o(cpu_dm)
    );

    tsi_cmem #(.STREAMS(STREAMS), .CHANS(CHANS), .BITS(BITS)) u_cmem (
        .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .next_chan_i(next_chan),
        .lo_o(cm_lo), .flags_o(cm_flags), .sel_o(sel),
        .cpu_lo_o(cpu_lo), .cpu_flags_o(cpu_flags)
    );

    tsi_tx #(.STREAMS(STREAMS), .CHANS(CHANS), .BITS(BITS)) u_tx (
        .clk_i(clk_i), .rst_ni(rst_ni), .bit_end_i(bit_end),
        .slot_end_i(slot_end), .chan_i(chan), .next_chan_i(next_chan),
        .par_i(par), .lo_i(cm_lo), .flags_i(cm_flags), .dm_i(dm_data),
        .src_o(src), .bank_o(bank), .st_o(st_o), .oe_o(oe), .ctl_o(ctl_o)
    );

    typedef struct packed {
        logic [BITS-1:0] rd;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cs_i && !we_i) begin
            if (!addr_i[AW]) begin
                s_d.rd = {{(BITS-2){1'b0}}, sel};
            end else begin
                case (sel)
                    SEL_CM_LO: s_d.rd = cpu_lo;
                    SEL_CM_HI: s_d.rd = {{(BITS-FLAG_W){1'b0}}, cpu_flags};
                    SEL_DATA:  s_d.rd = cpu_dm;
                    default:   s_d.rd = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o = s_q.rd;
    assign st_en_o = oe & {STREAMS{ode_i}};

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int STREAMS = 8,
    parameter int BITS    = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               ode_i,
    input logic               cs_i,
    input logic               we_i,
    input logic [BITS-1:0]    rdata_o,
    input logic [STREAMS-1:0] st_o,
    input logic [STREAMS-1:0] st_en_o,
    input logic               ctl_o,
    input logic               bit_end_i,
    input logic               slot_end_i
);

    a_r5_ode_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ode_i |-> (st_en_o == '0));

    a_r5_en_at_slot_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ode_i && $past(ode_i) && !$past(slot_end_i)) |-> $stable(st_en_o));

    a_r1_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(bit_end_i) |-> $stable(st_o));

    a_r6_ctl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(bit_end_i) |-> $stable(ctl_o));

    a_r7_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(cs_i) || $past(we_i)) |-> $stable(rdata_o));

endmodule

bind tsi_switch tsi_switch_chk #(.STREAMS(STREAMS), .BITS(BITS)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .ode_i(ode_i), .cs_i(cs_i), .we_i(we_i),
    .rdata_o(rdata_o), .st_o(st_o), .st_en_o(st_en_o), .ctl_o(ctl_o),
    .bit_end_i(bit_end), .slot_end_i(slot_end)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp = 1'b0;
    logic [7:0] st_in = '0;
    logic       ode = 1'b1;
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic [8:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] st_out, st_en;
    logic       ctl;

    tsi_switch u_tsi_switch (
        .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .st_i(st_in), .ode_i(ode),
        .cs_i(cs), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .st_o(st_out), .st_en_o(st_en), .ctl_o(ctl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int bc = 0;
    int fn = 0;
    bit fp_mid = 1'b0;

    // bench frame model: same pulse rule as R1
    always @(posedge clk) begin
        if (!rst_n) begin
            bc <= 0;
            fn <= 0;
        end else if (fp || bc == 511) begin
            bc <= 0;
            fn <= fn + 1;
        end else begin
            bc <= bc + 1;
        end
    end

    function automatic logic [7:0] src_byte(int f, int s, int c);
        return 8'((f * 29 + s * 32 + c) ^ 8'hA5);
    endfunction

    // input driver: bit (bc>>1)&7 of channel bc>>4, MSB first
    initial begin
        forever begin
            @(negedge clk);
            for (int s = 0; s < 8; s++) begin
                logic [7:0] b;
                b = src_byte(fn, s, (bc >> 4) & 31);
                st_in[s] = b[7 - ((bc >> 1) & 7)];
            end
            if (fp_mid && bc == 200) begin
                fp = 1'b1;
                fp_mid = 1'b0;
            end else begin
                fp = (bc == 511);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        cs = 1'b0;
        d = rdata;
    endtask

    function automatic logic [8:0] mem_addr(int s, int c);
        return {1'b1, 3'(s), 5'(c)};
    endfunction

    task automatic set_slot(int s, int c, logic [7:0] lo, logic [7:0] hi);
        cpu_wr(9'h000, 8'd0);
        cpu_wr(mem_addr(s, c), lo);
        cpu_wr(9'h000, 8'd1);
        cpu_wr(mem_addr(s, c), hi);
    endtask

    logic [7:0] cap_d   [8][32];
    logic       cap_en  [8][32];
    logic [7:0] cap_ctl [32];
    int         cap_f;

    task automatic capture_frame();
        do @(negedge clk); while (bc != 0);
        cap_f = fn;
        for (int k = 0; k < 512; k++) begin
            if (k % 2 == 1) begin
                for (int s = 0; s < 8; s++) begin
                    cap_d[s][k >> 4][7 - ((k >> 1) & 7)] = st_out[s];
                    if (((k >> 1) & 7) == 0) cap_en[s][k >> 4] = st_en[s];
                end
                cap_ctl[k >> 4][(k >> 1) & 7] = ctl;
            end
            @(negedge clk);
        end
    endtask

    function automatic int srcsel(int ss, int sc);
        return ss * 32 + sc;
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        check(rdata == 8'h00, "R9", "rdata after reset", rdata, 0);
        check(st_en == 8'h00, "R9", "enables after reset", st_en, 0);
        check(ctl == 1'b0, "R9", "ctl after reset", ctl, 0);
        cpu_rd(9'h000, d);
        check(d == 8'h00, "R9", "control register after reset", d, 0);
    endtask

    task automatic t_port();
        logic [7:0] d;
        cpu_wr(9'h000, 8'd1);
        cpu_rd(9'h000, d);
        check(d == 8'h01, "R7", "control register select", d, 1);
        cpu_wr(mem_addr(6, 30), 8'h0D);
        cpu_rd(mem_addr(6, 30), d);
        check(d == 8'h0D, "R7", "connect-high readback", d, 8'h0D);
        cpu_wr(9'h000, 8'd0);
        cpu_wr(mem_addr(6, 30), 8'h5E);
        cpu_rd(mem_addr(6, 30), d);
        check(d == 8'h5E, "R7", "connect-low readback", d, 8'h5E);
        set_slot(6, 30, 8'h00, 8'h00);
    endtask

    task automatic configure();
        set_slot(0, 5,  8'(srcsel(2, 9)),  8'h06);
        set_slot(0, 20, 8'(srcsel(3, 4)),  8'h02);
        set_slot(1, 0,  8'(srcsel(7, 31)), 8'h02);
        set_slot(5, 8,  8'(srcsel(4, 7)),  8'h02);
        set_slot(1, 7,  8'(srcsel(5, 3)),  8'h0E);
        set_slot(2, 0,  8'(srcsel(6, 31)), 8'h0A);
        set_slot(2, 7,  8'(srcsel(4, 7)),  8'h0A);
        set_slot(3, 10, 8'hC3,             8'h03);
        set_slot(4, 12, 8'h00,             8'h00);
    endtask

    task automatic t_switching();
        logic [7:0] e;
        capture_frame();
        capture_frame();
        // R2: minimum delay
        e = src_byte(cap_f - 1, 2, 9);
        check(cap_d[0][5] == e, "R2", "slot 0/5 later source", cap_d[0][5], e);
        e = src_byte(cap_f, 3, 4);
        check(cap_d[0][20] == e, "R2", "slot 0/20 earlier source", cap_d[0][20], e);
        e = src_byte(cap_f - 1, 7, 31);
        check(cap_d[1][0] == e, "R2", "slot 1/0 channel zero", cap_d[1][0], e);
        e = src_byte(cap_f, 4, 7);
        check(cap_d[5][8] == e, "R2", "slot 5/8 forwarded", cap_d[5][8], e);
        // R3: constant delay
        e = src_byte(cap_f - 1, 5, 3);
        check(cap_d[1][7] == e, "R3", "slot 1/7 one frame", cap_d[1][7], e);
        e = src_byte(cap_f - 1, 6, 31);
        check(cap_d[2][0] == e, "R3", "slot 2/0 source ch31", cap_d[2][0], e);
        e = src_byte(cap_f - 1, 4, 7);
        check(cap_d[2][7] == e, "R3", "slot 2/7 same channel", cap_d[2][7], e);
        // R4: message mode
        check(cap_d[3][10] == 8'hC3, "R4", "message byte", cap_d[3][10], 8'hC3);
        // R5: per-slot enable
        check(cap_en[0][5] == 1'b1, "R5", "enabled slot", cap_en[0][5], 1);
        check(cap_en[4][12] == 1'b0, "R5", "disabled slot", cap_en[4][12], 0);
        // R6: control stream, bit j of channel c = stream j
        check(cap_ctl[5][0] == 1'b1, "R6", "ctl slot 0/5", cap_ctl[5][0], 1);
        check(cap_ctl[7][1] == 1'b1, "R6", "ctl slot 1/7", cap_ctl[7][1], 1);
        check(cap_ctl[5][1] == 1'b0, "R6", "ctl slot 1/5", cap_ctl[5][1], 0);
        check(cap_ctl[20] == 8'h00, "R6", "ctl channel 20", cap_ctl[20], 0);
    endtask

    task automatic t_dm_read();
        logic [7:0] d, e;
        cpu_wr(9'h000, 8'd2);
        do @(negedge clk); while (bc != 20);
        e = src_byte(fn - 1, 2, 9);
        cpu_rd(mem_addr(2, 9), d);
        check(d == e, "R8", "data memory read", d, e);
        cpu_wr(9'h000, 8'd0);
    endtask

    task automatic t_ode();
        ode = 1'b0;
        capture_frame();
        check(cap_en[0][5] == 1'b0, "R5", "ode low slot 0/5", cap_en[0][5], 0);
        check(cap_en[1][7] == 1'b0, "R5", "ode low slot 1/7", cap_en[1][7], 0);
        ode = 1'b1;
    endtask

    task automatic t_realign();
        logic [7:0] e;
        do @(negedge clk); while (bc != 100);
        fp_mid = 1'b1;
        capture_frame();
        e = src_byte(cap_f - 1, 2, 9);
        check(cap_d[0][5] == e, "R1", "after early pulse slot 0/5", cap_d[0][5], e);
        e = src_byte(cap_f - 1, 5, 3);
        check(cap_d[1][7] == e, "R1", "after early pulse slot 1/7", cap_d[1][7], e);
        e = src_byte(cap_f, 3, 4);
        check(cap_d[0][20] == e, "R1", "after early pulse slot 0/20", cap_d[0][20], e);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_port();
        configure();
        t_switching();
        t_dm_read();
        t_ode();
        t_realign();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule